// File: doc/BRIEF.md
# Channel/Gain Scan Queue

This block holds the scan list for a multiplexed 12-bit converter front end. Each slot of the list names one of eight input channels and a 4-bit range code for the gain stage. The host loads a slot through an 8-bit register port. It first writes the slot number to an index register and then writes the slot contents to a data register. A third register sets the index of the last active slot.

Acquisition begins with an arm pulse while the acquisition enable is high. The arm is refused when the loaded list breaks the slot rules of the front end. With more than one active slot, an even channel may sit only in an even slot and an odd channel only in an odd slot, and the number of active slots must be even. A single-slot list is always accepted.

While running, the block drives the mux and gain stage from the current slot. On each conversion strobe it emits a 16-bit result word that holds the sample and the channel it came from, and then steps to the next slot. After the last active slot it wraps to slot 0.

Top module: `chgain_scanq`

## Requirements
- R1: After reset, `running`, `cfg_err` and `res_valid` are 0, the slot pointer is 0 and every slot holds channel 0 with range code 0, so `mux_chan` and `range_code` read 0.
- R2: A slot byte maps bits 2:0 to the channel and bits 7:4 to the range code, and bit 3 is discarded. `mux_chan` and `range_code` always show the slot at the current pointer.
- R3: `unipolar` equals bit 2 of the current range code, which is bit 6 of the slot byte.
- R4: On a write, offset 6 loads the slot index, offset 7 stores the byte into the slot at that index, and offset 4 loads the last-active index. A write to any other offset changes nothing.
- R5: A list is legal when the last index is 0. It is also legal when the last index is odd and every slot i from 0 to the last index holds a channel whose lowest bit equals the lowest bit of i. No other list is legal.
- R6: An arm on an illegal list sets `cfg_err` and leaves `running` at 0. `cfg_err` keeps its value until the next arm on a legal list clears it.
- R7: An arm on a legal list while `acq_en` is high sets `running` in the next cycle, moves the pointer to slot 0 and latches the last index for the run.
- R8: A conversion strobe while running and not arming makes `res_valid` high for one cycle in the next cycle. The result holds `{adc_data, 1'b0, channel of the current slot}`, and the pointer then advances, wrapping to 0 after the latched last index.
- R9: While `acq_en` is low, `running` clears and the pointer returns to 0, and strobes and arms have no effect.
- R10: An arm during a run restarts the list at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Register byte offset |
| wr_data | input | 8 | Register write byte |
| acq_en | input | 1 | Acquisition enable (level) |
| arm | input | 1 | Start request pulse |
| conv_strobe | input | 1 | Conversion complete strobe |
| adc_data | input | 12 | Converted sample |
| mux_chan | output | 3 | Channel select for the current slot |
| range_code | output | 4 | Gain/range code for the current slot |
| unipolar | output | 1 | Unipolar mode of the current range |
| running | output | 1 | Acquisition active |
| cfg_err | output | 1 | Sticky illegal-list flag |
| res_valid | output | 1 | Result word valid pulse |
| result | output | 16 | Sample in 15:4, channel in 3:0 |

## Verification
On every cycle, the assertions check that a disabled enable clears the run and the pointer, and that a result appears only after a strobe taken while running. They also check that the pointer wraps after the latched last index, that a run starts only from a legal arm, and that a raised error never coincides with a run. The bench alone shows the value-level behaviour. This covers the full mapping of slot bytes onto channel, range and unipolar outputs, the legality verdict over every channel pair in a two-slot list and over several odd-length and misplaced lists, the contents and order of result words across wrap and restart, and the lack of effect of writes to unused offsets.

// File: rtl/scanq_pkg.sv
package scanq_pkg;
  typedef struct packed {
    logic [3:0] rng;
    logic [2:0] chan;
  } qent_t;

  localparam logic [2:0] OFS_LAST = 3'd4;
  localparam logic [2:0] OFS_IDX  = 3'd6;
  localparam logic [2:0] OFS_DATA = 3'd7;
endpackage

// File: rtl/scanq_regs.sv
module scanq_regs
  import scanq_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] last_q,
  output logic             ent_we,
  output qent_t            ent_wdata
);
  logic idx_en, last_en;
  logic unused_bit3;

  assign unused_bit3 = wr_data[3];
  assign idx_en      = wr_en && (wr_addr == OFS_IDX);
  assign last_en     = wr_en && (wr_addr == OFS_LAST);
  assign ent_we      = wr_en && (wr_addr == OFS_DATA);
  assign ent_wdata   = '{rng: wr_data[7:4], chan: wr_data[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      if (idx_en)  idx_q  <= wr_data[IDX_W-1:0];
      if (last_en) last_q <= wr_data[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/scanq_mem.sv
module scanq_mem
  import scanq_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  qent_t            wdata,
  input  logic [IDX_W-1:0] raddr,
  output qent_t            rdata,
  output logic [DEPTH-1:0] bad
);
  qent_t slot_q [DEPTH];

  assign rdata = slot_q[raddr];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      localparam logic SLOT_ODD = (i % 2) == 1;
      logic bad_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_q[i] <= '0;
          bad_q     <= SLOT_ODD;
        end else if (we && (waddr == IDX_W'(i))) begin
          slot_q[i] <= wdata;
          bad_q     <= wdata.chan[0] ^ SLOT_ODD;
        end
      end
      assign bad[i] = bad_q;
    end
  endgenerate
endmodule

// File: rtl/scanq_legal.sv
module scanq_legal #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] bad,
  input  logic [IDX_W-1:0] last,
  output logic             cfg_ok
);
  logic [DEPTH-1:0] viol;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_mask
      assign viol[i] = bad[i] && (IDX_W'(i) <= last);
    end
  endgenerate

  assign cfg_ok = (last == '0) || (last[0] && (viol == '0));
endmodule

// File: rtl/scanq_seq.sv
module scanq_seq
  import scanq_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int ADC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_en,
  input  logic             arm,
  input  logic             conv_strobe,
  input  logic [ADC_W-1:0] adc_data,
  input  logic             cfg_ok,
  input  logic [IDX_W-1:0] last_in,
  input  qent_t            cur_ent,
  output logic [IDX_W-1:0] ptr_q,
  output logic             run_q,
  output logic             err_q,
  output logic             vld_q,
  output logic [ADC_W+3:0] res_q
);
  logic [IDX_W-1:0] ptr_d, rlast_q, rlast_d;
  logic             run_d, err_d, vld_d, res_en;
  logic [ADC_W+3:0] res_d;

  always_comb begin
    ptr_d   = ptr_q;
    rlast_d = rlast_q;
    run_d   = run_q;
    err_d   = err_q;
    vld_d   = 1'b0;
    res_en  = 1'b0;
    res_d   = {adc_data, 1'b0, cur_ent.chan};
    if (!acq_en) begin
      run_d = 1'b0;
      ptr_d = '0;
    end else if (arm) begin
      ptr_d   = '0;
      rlast_d = last_in;
      run_d   = cfg_ok;
      err_d   = !cfg_ok;
    end else if (run_q && conv_strobe) begin
      vld_d  = 1'b1;
      res_en = 1'b1;
      ptr_d  = (ptr_q == rlast_q) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rlast_q <= '0;
      run_q   <= 1'b0;
      err_q   <= 1'b0;
      vld_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      ptr_q   <= ptr_d;
      rlast_q <= rlast_d;
      run_q   <= run_d;
      err_q   <= err_d;
      vld_q   <= vld_d;
      if (res_en) res_q <= res_d;
    end
  end

  // R9
  acq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_en |=> (!run_q && ptr_q == '0));
  // R8
  res_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(run_q && conv_strobe && acq_en && !arm));
  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && acq_en && !arm && conv_strobe && ptr_q == rlast_q) |=> ptr_q == '0);
  // R7
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(cfg_ok && arm && acq_en));
  // R6
  err_norun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !run_q);
  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en && arm) |=> ptr_q == '0);
endmodule

// File: rtl/chgain_scanq.sv
module chgain_scanq
  import scanq_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int ADC_W = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             acq_en,
  input  logic             arm,
  input  logic             conv_strobe,
  input  logic [ADC_W-1:0] adc_data,
  output logic [2:0]       mux_chan,
  output logic [3:0]       range_code,
  output logic             unipolar,
  output logic             running,
  output logic             cfg_err,
  output logic             res_valid,
  output logic [ADC_W+3:0] result
);
  logic [IDX_W-1:0] idx_q, last_q, ptr_q;
  logic             ent_we, cfg_ok;
  qent_t            ent_wdata, cur_ent;
  logic [DEPTH-1:0] bad;

  scanq_regs #(.IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .idx_q(idx_q), .last_q(last_q),
    .ent_we(ent_we), .ent_wdata(ent_wdata));

  scanq_mem #(.DEPTH(DEPTH)) mem_i (
    .clk(clk), .rst_n(rst_n), .we(ent_we), .waddr(idx_q),
    .wdata(ent_wdata), .raddr(ptr_q), .rdata(cur_ent), .bad(bad));

  scanq_legal #(.DEPTH(DEPTH)) legal_i (
    .bad(bad), .last(last_q), .cfg_ok(cfg_ok));

  scanq_seq #(.IDX_W(IDX_W), .ADC_W(ADC_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .arm(arm),
    .conv_strobe(conv_strobe), .adc_data(adc_data), .cfg_ok(cfg_ok),
    .last_in(last_q), .cur_ent(cur_ent), .ptr_q(ptr_q), .run_q(running),
    .err_q(cfg_err), .vld_q(res_valid), .res_q(result));

  assign mux_chan   = cur_ent.chan;
  assign range_code = cur_ent.rng;
  assign unipolar   = cur_ent.rng[2];
endmodule

// File: tb/chgain_scanq_tb.sv
module chgain_scanq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        acq_en = 1'b0;
  logic        arm = 1'b0;
  logic        conv_strobe = 1'b0;
  logic [11:0] adc_data = '0;
  logic [2:0]  mux_chan;
  logic [3:0]  range_code;
  logic        unipolar, running, cfg_err, res_valid;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chgain_scanq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .acq_en(acq_en), .arm(arm),
    .conv_strobe(conv_strobe), .adc_data(adc_data), .mux_chan(mux_chan),
    .range_code(range_code), .unipolar(unipolar), .running(running),
    .cfg_err(cfg_err), .res_valid(res_valid), .result(result));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_arm();
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic strobe(logic [11:0] v);
    @(negedge clk);
    conv_strobe = 1'b1; adc_data = v;
    @(negedge clk);
    conv_strobe = 1'b0;
  endtask

  task automatic load(int slot, logic [7:0] b);
    wr(3'd6, 8'(slot));
    wr(3'd7, b);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] chans [4];
    logic [7:0] bytes [4];
    chans = '{3'd0, 3'd3, 3'd6, 3'd1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 running", running, 0);
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 mux_chan", mux_chan, 0);
    chk("R1 range_code", range_code, 0);

    // R2 R3 exhaustive slot byte mapping on slot 0
    wr(3'd6, 8'd0);
    for (int b = 0; b < 256; b++) begin
      wr(3'd7, 8'(b));
      chk("R2 chan", mux_chan, b & 7);
      chk("R2 range", range_code, (b >> 4) & 15);
      chk("R3 unipolar", unipolar, (b >> 6) & 1);
    end

    // R4 unused offsets and index redirection
    wr(3'd7, 8'h35);
    for (int a = 0; a < 6; a++) begin
      if (a == 4) continue;
      wr(3'(a), 8'hFF);
      chk("R4 other offset no effect", {range_code, 1'b0, mux_chan}, 8'h35);
    end
    load(1, 8'hA2);
    chk("R4 write to slot1 leaves slot0", {range_code, 1'b0, mux_chan}, 8'h35);

    // R5 R6 R7 two-slot legality sweep
    acq_en = 1'b1;
    wr(3'd4, 8'd1);
    for (int c0 = 0; c0 < 8; c0++) begin
      for (int c1 = 0; c1 < 8; c1++) begin
        bit legal;
        legal = ((c0 % 2) == 0) && ((c1 % 2) == 1);
        load(0, 8'(c0));
        load(1, 8'(c1));
        pulse_arm();
        chk("R5 R6 cfg_err pair", cfg_err, !legal);
        chk("R7 running pair", running, legal);
      end
    end

    // R5 single slot always legal, even with odd channel
    load(0, 8'h05);
    wr(3'd4, 8'd0);
    pulse_arm();
    chk("R5 single slot legal", cfg_err, 0);
    chk("R7 single slot runs", running, 1);

    // R5 odd length with good parity is illegal
    load(0, 8'd0); load(1, 8'd1); load(2, 8'd2);
    wr(3'd4, 8'd2);
    pulse_arm();
    chk("R5 odd length err", cfg_err, 1);
    chk("R6 odd length no run", running, 0);
    repeat (5) @(negedge clk);
    chk("R6 cfg_err sticky", cfg_err, 1);

    // R5 length 4 with slot3 even channel is illegal
    load(3, 8'd4);
    wr(3'd4, 8'd3);
    pulse_arm();
    chk("R5 slot3 parity err", cfg_err, 1);

    // R8 run with wrap over four slots
    for (int s = 0; s < 4; s++) begin
      bytes[s] = {4'(s + 8), 1'b0, chans[s]};
      load(s, bytes[s]);
    end
    pulse_arm();
    chk("R6 legal arm clears err", cfg_err, 0);
    chk("R7 run start", running, 1);
    chk("R7 start at slot0", mux_chan, chans[0]);
    for (int k = 0; k < 10; k++) begin
      logic [11:0] v;
      v = 12'(12'h100 + k * 37);
      chk("R2 current slot chan", mux_chan, chans[k % 4]);
      chk("R2 current slot range", range_code, (k % 4) + 8);
      strobe(v);
      chk("R8 res_valid", res_valid, 1);
      chk("R8 result word", result, {v, 1'b0, chans[k % 4]});
    end
    @(negedge clk);
    chk("R8 valid one cycle", res_valid, 0);

    // R10 restart mid-run (pointer at slot 2 now)
    chk("R8 pointer at slot2", mux_chan, chans[2]);
    pulse_arm();
    chk("R10 restart slot0", mux_chan, chans[0]);
    strobe(12'hABC);
    chk("R10 first result after restart", result, {12'hABC, 1'b0, chans[0]});

    // R9 disable clears and ignores strobes
    @(negedge clk);
    acq_en = 1'b0;
    @(negedge clk);
    chk("R9 running off", running, 0);
    chk("R9 pointer slot0", mux_chan, chans[0]);
    strobe(12'h555);
    chk("R9 strobe ignored", res_valid, 0);
    pulse_arm();
    chk("R9 arm ignored", running, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule